// File: doc/BRIEF.md
# Overlapping 1010 Serial Pattern Detector

This block samples a one-bit serial stream on every rising clock edge and flags each occurrence of the pattern 1010. Occurrences may share bits: the tail of one match can serve as the head of the next. Two independent state machines watch the same stream, and each drives its own flag.

The first machine is state-only (Moore style) and has five states, one for each count of matched bits from 0 to 4: `MR_NONE`, `MR_ONE`, `MR_TWO`, `MR_THREE` and `MR_FULL`. Its flag is a decode of the `MR_FULL` state, so it changes only at clock edges.

The second machine is input-dependent (Mealy style) and has four states: `ML_NONE`, `ML_ONE`, `ML_TWO` and `ML_THREE`. Its flag is raised while the machine sits in `ML_THREE` and the present input is 0. It therefore reports a match during the cycle in which the final bit is presented, which is one cycle ahead of the Moore flag. Placing the two side by side shows that one-cycle offset.

The transitions, written as state --input--> next, are as follows.

Moore machine:
- NONE --1--> ONE and NONE --0--> NONE
- ONE --0--> TWO and ONE --1--> ONE
- TWO --1--> THREE and TWO --0--> NONE
- THREE --0--> FULL and THREE --1--> ONE
- FULL --1--> THREE and FULL --0--> NONE

Mealy machine:
- NONE --1--> ONE and NONE --0--> NONE
- ONE --0--> TWO and ONE --1--> ONE
- TWO --1--> THREE and TWO --0--> NONE
- THREE --0/hit--> TWO and THREE --1--> ONE

Both machines use binary state encoding: three flip-flops for the Moore machine and two for the Mealy machine.

Top module: `pat1010_detector`

## Requirements
- R1: Every occurrence of 1010 in the input stream is flagged, including occurrences that overlap an earlier one. For example, 1010101010 yields four detections.
- R2: `moore_hit` is 1 only in the cycle that follows the edge at which the final 0 of a match was sampled. It is a pure function of state.
- R3: `mealy_hit` is 1 exactly when the bits sampled since reset end in 101 and the present `x_in` is 0.
- R4: For the same detection, `moore_hit` rises one clock cycle after `mealy_hit`. In every cycle after reset, `moore_hit` equals the value that `mealy_hit` had in the previous cycle.
- R5: After a Moore detection, an input of 1 followed by 0 produces a new detection. An input of 0 instead returns the Moore machine to no match, so that 1010 must be presented again in full.
- R6: After a Mealy detection, the suffix 10 is retained, so the input pair 1, 0 yields another detection.
- R7: While `rst` is 1, both outputs are 0. After reset, both machines restart with zero matched bits, so bits presented before reset never contribute to a match.
- R8: `mealy_hit` follows `x_in` within a cycle. In the 101-matched state, changing `x_in` between clock edges toggles `mealy_hit` without a clock edge, while `moore_hit` stays unchanged.
- R9: For the input stream 0101011001010100, applied first bit first, `mealy_hit` is 1 while bits 4, 12 and 14 are presented (counting from 0). `moore_hit` is 1 during bits 5, 13 and 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `x_in` is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial data bit |
| moore_hit | output | 1 | State-decoded detect flag |
| mealy_hit | output | 1 | Detect flag formed from state and present input |

## Verification
The hardest situation to reach from the ports is the Mealy flag changing inside a single cycle. To show it, the bench must hold the detector in the 101-matched state and then alter `x_in` twice between two rising edges, checking `mealy_hit` after each change. The bench reaches that state by shifting in 1, 0, 1. It then drives `x_in` to 1 and then to 0 within one low phase of the clock, checking both flags after each change. It commits to the 0 before the edge so that the reference model stays aligned. Overlap after each machine's detection is reached with long alternating runs, and also with runs that break after a detection.

// File: rtl/pat_det_pkg.sv
package pat_det_pkg;

    localparam int MOORE_SW = 3;
    localparam int MEALY_SW = 2;

    typedef enum logic [MOORE_SW-1:0] {
        MR_NONE  = 3'd0,
        MR_ONE   = 3'd1,
        MR_TWO   = 3'd2,
        MR_THREE = 3'd3,
        MR_FULL  = 3'd4
    } moore_st_t;

    typedef enum logic [MEALY_SW-1:0] {
        ML_NONE  = 2'd0,
        ML_ONE   = 2'd1,
        ML_TWO   = 2'd2,
        ML_THREE = 2'd3
    } mealy_st_t;

endpackage

// File: rtl/pd_moore_fsm.sv
module pd_moore_fsm
    import pat_det_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic hit
);

    moore_st_t cur_st;
    moore_st_t nxt_st;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_st <= MR_NONE;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // next-state logic
    always_comb begin
        nxt_st = MR_NONE;
        unique case (cur_st)
            MR_NONE:  nxt_st = bit_in ? MR_ONE   : MR_NONE;
            MR_ONE:   nxt_st = bit_in ? MR_ONE   : MR_TWO;
            MR_TWO:   nxt_st = bit_in ? MR_THREE : MR_NONE;
            MR_THREE: nxt_st = bit_in ? MR_ONE   : MR_FULL;
            MR_FULL:  nxt_st = bit_in ? MR_THREE : MR_NONE;
            default:  nxt_st = MR_NONE;
        endcase
    end

    // output logic: a function of state only
    always_comb begin
        hit = 1'b0;
        unique case (cur_st)
            MR_FULL: hit = 1'b1;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pd_mealy_fsm.sv
module pd_mealy_fsm
    import pat_det_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic hit
);

    mealy_st_t cur_st;
    mealy_st_t nxt_st;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_st <= ML_NONE;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // next-state logic
    always_comb begin
        nxt_st = ML_NONE;
        unique case (cur_st)
            ML_NONE:  nxt_st = bit_in ? ML_ONE   : ML_NONE;
            ML_ONE:   nxt_st = bit_in ? ML_ONE   : ML_TWO;
            ML_TWO:   nxt_st = bit_in ? ML_THREE : ML_NONE;
            ML_THREE: nxt_st = bit_in ? ML_ONE   : ML_TWO;
            default:  nxt_st = ML_NONE;
        endcase
    end

    // output logic: depends on state and the present input; held low in reset
    always_comb begin
        hit = 1'b0;
        unique case (cur_st)
            ML_THREE: hit = !bit_in && !rst;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pat1010_detector.sv
module pat1010_detector (
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic moore_hit,
    output logic mealy_hit
);

    pd_moore_fsm u_moore (
        .clk    (clk),
        .rst    (rst),
        .bit_in (x_in),
        .hit    (moore_hit)
    );

    pd_mealy_fsm u_mealy (
        .clk    (clk),
        .rst    (rst),
        .bit_in (x_in),
        .hit    (mealy_hit)
    );

endmodule

// File: rtl/pat1010_detector_chk.sv
module pat1010_detector_chk (
    input logic clk,
    input logic rst,
    input logic x_in,
    input logic moore_hit,
    input logic mealy_hit
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    // R2
    moore_after_zero_chk: assert property (@(posedge clk) disable iff (rst || rst_d)
        moore_hit |-> !$past(x_in));

    // R3
    mealy_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mealy_hit |-> !x_in);

    // R4
    moore_lags_mealy_chk: assert property (@(posedge clk) disable iff (rst || rst_d)
        moore_hit == $past(mealy_hit));

    // R5
    moore_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (moore_hit && x_in ##1 !x_in) |=> moore_hit);

    // R6
    mealy_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (mealy_hit ##1 x_in ##1 !x_in) |-> mealy_hit);

    // R7
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !moore_hit);

    // R7
    reset_mealy_low_chk: assert property (@(posedge clk)
        rst |-> !mealy_hit);

endmodule

bind pat1010_detector pat1010_detector_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .x_in      (x_in),
    .moore_hit (moore_hit),
    .mealy_hit (mealy_hit)
);

// File: tb/pat1010_detector_tb_top.sv
module pat1010_detector_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic moore_hit;
    logic mealy_hit;

    int total = 0;
    int bad = 0;

    // reference model state
    int       nbits = 0;
    bit [2:0] tail  = 3'b000;
    bit       prev_hit = 1'b0;

    always #4 clk = ~clk;

    pat1010_detector dut_i (
        .clk       (clk),
        .rst       (rst),
        .x_in      (x_in),
        .moore_hit (moore_hit),
        .mealy_hit (mealy_hit)
    );

    function automatic bit exp_mealy(input bit b);
        return (rst == 1'b0) && (nbits >= 3) && (tail == 3'b101) && (b == 1'b0);
    endfunction

    task automatic check(input string tag, input logic act, input bit exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_update(input bit b);
        if (rst) begin
            nbits = 0; tail = 3'b000; prev_hit = 1'b0;
        end else begin
            prev_hit = exp_mealy(b);
            tail = {tail[1:0], b};
            nbits++;
        end
    endtask

    task automatic step(input bit b, input string tag);
        @(negedge clk);
        x_in = b;
        #2;
        check(tag, mealy_hit, exp_mealy(b), "mealy_hit");
        check(tag, moore_hit, prev_hit, "moore_hit");
        @(posedge clk);
        model_update(b);
    endtask

    task automatic send(input string bits, input string tag);
        for (int i = 0; i < bits.len(); i++) begin
            step(bits[i] == "1", tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        x_in = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(posedge clk);
            model_update(1'b0);
            #2;
            check("R7", mealy_hit, 1'b0, "mealy_hit in reset");
            check("R7", moore_hit, 1'b0, "moore_hit in reset");
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset();

        // R9: stream with detections at bits 4, 12, 14 (Mealy) and 5, 13, 15 (Moore)
        send("0101011001010100", "R9");
        step(1'b0, "R4");

        // R1 R6 R5: long alternating run, overlapping detections
        do_reset();
        send("1010101010", "R1");
        send("10", "R6");
        send("0", "R5");
        send("1010", "R5");
        send("0", "R4");

        // R1: broken prefix 1011 then a match
        send("1011010", "R1");
        send("0", "R2");

        // R7: reset mid-pattern drops earlier bits
        send("101", "R7");
        do_reset();
        send("0", "R7");
        send("1010", "R7");
        send("0", "R3");

        // R8: intra-cycle response of the Mealy flag
        send("101", "R8");
        @(negedge clk);
        x_in = 1'b1;
        #1;
        check("R8", mealy_hit, 1'b0, "mealy_hit with x=1");
        check("R8", moore_hit, 1'b0, "moore_hit with x=1");
        x_in = 1'b0;
        #1;
        check("R8", mealy_hit, 1'b1, "mealy_hit with x=0");
        check("R8", moore_hit, 1'b0, "moore_hit with x=0");
        @(posedge clk);
        model_update(1'b0);
        step(1'b1, "R2");
        step(1'b0, "R3");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule